// File: doc/BRIEF.md
# Modem Status Register with CTS Delta Tracking

This block holds the modem status byte of one serial port as seen by the host. It follows a single modem input, clear-to-send, and reports two things about it: the present level, and a sticky flag that records any change of that level since the host last looked. The other three modem inputs of a classic serial port are not wired in. Their bits always read as zero.

The level comes from one of two sources. Normally it is the external active-low clear-to-send pin, passed through a synchronizer. When the loopback enable from the modem control register is set, the level is taken from that register's request-to-send bit instead, and the pin is ignored. The host reads the byte combinationally on `rd_data` while it holds `rd_stb` high, for one or more cycles. The clock edge at which `rd_stb` is first sampled low after being high is the trailing edge of the read. No change flag is ever set while a read is in progress. What happens at the trailing edge depends on whether the level moved during the read and on the flag's value. That rule keeps the byte stable for the whole read and stops an event from being lost without trace.

The block has no data stream, so there is no valid/ready handshake. Every pin is a plain control or status signal.

Top module: `msr_cts_status`

## Requirements
- R1: While reset is held and afterwards until the level first changes, bit 0 (delta flag) of `rd_data` is 0. Once the synchronizer has filled after reset, bit 4 (level) equals the level of the selected source, and no delta is raised by that initial fill.
- R2: With `loop_en` = 0, bit 4 equals the inverse of `cts_n`. It follows a change on `cts_n` exactly SYNC_STAGES+1 clock edges after that change.
- R3: With `loop_en` = 1, bit 4 equals `mcr_rts` one clock edge after it changes, and changes on `cts_n` affect neither bit 4 nor bit 0.
- R4: Outside a read, any change of the effective level sets bit 0 at the same clock edge at which bit 4 takes the new level. Bit 0 then stays 1.
- R5: Bit 0 holds its value at every clock edge at which `rd_stb` is sampled high. A read during which the level does not change clears bit 0 at its trailing edge. Bit 4 is never altered by a read.
- R6: If the level changes during a read and bit 0 was 0, bit 0 stays 0 until the trailing edge and becomes 1 there.
- R7: If the level changes during a read and bit 0 was already 1, bit 0 becomes 0 at the trailing edge instead of staying set.
- R8: Bits 1, 2, 3, 5, 6 and 7 of `rd_data` always read 0.
- R9: Switching `loop_en` counts as a level change whenever the two sources differ, and sets bit 0 as in R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Host read strobe, high for the whole read, synchronous to clk |
| loop_en | input | 1 | Loopback enable from the modem control register |
| mcr_rts | input | 1 | Request-to-send bit of the modem control register (1 = asserted) |
| cts_n | input | 1 | External clear-to-send pin, active low, asynchronous |
| rd_data | output | 8 | Status byte: bit 0 delta flag, bit 4 level, other bits 0 |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. This gives a pin-to-level latency of four edges, which makes an off-by-one in the synchronizer chain or in the warm-up counter visible at the sampled cycle. The larger setting also widens the window after reset in which a falsely detected startup delta would show. The reads the bench issues last for several cycles, so changes can be placed at the start, in the middle and at the trailing edge of a read, with the flag either clear or set.

// File: rtl/msr_pkg.sv
package msr_pkg;

  // Role a bit of the status byte plays.
  typedef enum logic [1:0] {
    ROLE_ZERO  = 2'd0,
    ROLE_DELTA = 2'd1,
    ROLE_LEVEL = 2'd2
  } bit_role_e;

  function automatic bit_role_e role_of(input int idx, input int delta_bit, input int level_bit);
    if (idx == delta_bit) return ROLE_DELTA;
    if (idx == level_bit) return ROLE_LEVEL;
    return ROLE_ZERO;
  endfunction

endpackage

// File: rtl/msr_sync.sv
// Multi-flop synchronizer. Resets to the inactive (high) pin level.
module msr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= 1'b1;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/msr_level_track.sv
// Selects the effective clear-to-send level, registers it and reports
// a change once the synchronizer has been filled after reset.
module msr_level_track #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic loop_en,
  input  logic mcr_rts,
  input  logic pin_sync_n,
  output logic level_q,
  output logic change
);
  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int CW       = $clog2(WARM_MAX + 1);

  logic          eff_level;
  logic [CW-1:0] warm_cnt;
  logic          warm_done;

  assign eff_level = loop_en ? mcr_rts : ~pin_sync_n;
  assign warm_done = (warm_cnt == CW'(WARM_MAX));
  assign change    = warm_done && (eff_level != level_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q  <= 1'b0;
      warm_cnt <= '0;
    end else begin
      level_q <= eff_level;
      if (!warm_done) warm_cnt <= warm_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/msr_delta_ctl.sv
// Delta flag with read-cycle handling: no set while reading, outcome
// resolved at the trailing edge of the read.
module msr_delta_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic change,
  output logic delta
);
  logic rd_q;
  logic pend;
  logic trailing;

  assign trailing = rd_q && !rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      pend  <= 1'b0;
      delta <= 1'b0;
    end else begin
      rd_q <= rd_stb;
      if (rd_stb) begin
        if (change) pend <= 1'b1;
      end else if (trailing) begin
        delta <= (pend ? ~delta : 1'b0) | change;
        pend  <= 1'b0;
      end else begin
        delta <= delta | change;
      end
    end
  end
endmodule

// File: rtl/msr_cts_status.sv
module msr_cts_status #(
  parameter int DATA_W      = 8,
  parameter int DELTA_BIT   = 0,
  parameter int LEVEL_BIT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              loop_en,
  input  logic              mcr_rts,
  input  logic              cts_n,
  output logic [DATA_W-1:0] rd_data
);
  import msr_pkg::*;

  logic pin_sync_n;
  logic level_q;
  logic change;
  logic delta;

  msr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cts_n),
    .dout (pin_sync_n)
  );

  msr_level_track #(.SYNC_STAGES(SYNC_STAGES)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .mcr_rts   (mcr_rts),
    .pin_sync_n(pin_sync_n),
    .level_q   (level_q),
    .change    (change)
  );

  msr_delta_ctl u_delta (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_stb(rd_stb),
    .change(change),
    .delta (delta)
  );

  generate
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (role_of(b, DELTA_BIT, LEVEL_BIT) == ROLE_DELTA) begin : g_d
        assign rd_data[b] = delta;
      end else if (role_of(b, DELTA_BIT, LEVEL_BIT) == ROLE_LEVEL) begin : g_l
        assign rd_data[b] = level_q;
      end else begin : g_z
        assign rd_data[b] = 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/msr_cts_checker.sv
module msr_cts_checker #(
  parameter int DATA_W      = 8,
  parameter int DELTA_BIT   = 0,
  parameter int LEVEL_BIT   = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic              loop_en,
  input logic              mcr_rts,
  input logic [DATA_W-1:0] rd_data
);
  localparam int ARM_MAX = SYNC_STAGES + 2;
  localparam int AW      = $clog2(ARM_MAX + 1);
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << DELTA_BIT) | (DATA_W'(1) << LEVEL_BIT);

  logic [AW-1:0] edges;
  logic          armed1;
  logic          armed_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges <= '0;
    else if (edges != AW'(ARM_MAX)) edges <= edges + 1'b1;
  end
  assign armed1     = (edges != '0);
  assign armed_full = (edges == AW'(ARM_MAX));

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED_MASK) == '0); // R8

  AST_HOLD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    armed1 && rd_stb |=> $stable(rd_data[DELTA_BIT])); // R5

  AST_NO_SET_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    armed1 && $rose(rd_data[DELTA_BIT]) |-> !$past(rd_stb)); // R6

  AST_LOOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    armed1 && $past(loop_en) |-> rd_data[LEVEL_BIT] == $past(mcr_rts)); // R3

  AST_SET_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    armed_full && !$past(rd_stb) && (rd_data[LEVEL_BIT] != $past(rd_data[LEVEL_BIT]))
    |-> rd_data[DELTA_BIT]); // R4
endmodule

bind msr_cts_status msr_cts_checker #(
  .DATA_W     (DATA_W),
  .DELTA_BIT  (DELTA_BIT),
  .LEVEL_BIT  (LEVEL_BIT),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rd_stb (rd_stb),
  .loop_en(loop_en),
  .mcr_rts(mcr_rts),
  .rd_data(rd_data)
);

// File: tb/msr_cts_status_bench.sv
`timescale 1ns/1ps
module msr_cts_status_bench;
  localparam int SYNC = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0;
  logic       loop_en = 1'b0;
  logic       mcr_rts = 1'b0;
  logic       cts_n = 1'b1;
  logic [7:0] rd_data;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  msr_cts_status #(.SYNC_STAGES(SYNC)) u_msr_cts_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_stb (rd_stb),
    .loop_en(loop_en),
    .mcr_rts(mcr_rts),
    .cts_n  (cts_n),
    .rd_data(rd_data)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_of(input logic lvl, input logic d);
    return {3'b000, lvl, 3'b000, d};
  endfunction

  // Read lasting len cycles; returns after the trailing edge is processed.
  task automatic host_read(input int len);
    rd_stb = 1'b1;
    step(len);
    rd_stb = 1'b0;
    step(1);
  endtask

  task automatic t_reset;
    cts_n = 1'b0; loop_en = 1'b0; rst_n = 1'b0;
    step(3);
    chk("R1 in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    step(SYNC + 4);
    chk("R1 after fill", rd_data, byte_of(1'b1, 1'b0));
  endtask

  task automatic t_ext_level;
    cts_n = 1'b1;
    step(SYNC);
    chk("R2 not yet", rd_data, byte_of(1'b1, 1'b0));
    step(1);
    chk("R2 level low", rd_data, byte_of(1'b0, 1'b1));
    chk("R4 delta set", {7'd0, rd_data[0]}, 8'h01);
    step(3);
    chk("R4 sticky", rd_data, byte_of(1'b0, 1'b1));
    chk("R8 unused", rd_data & 8'hEE, 8'h00);
  endtask

  task automatic t_read_clear;
    rd_stb = 1'b1;
    step(3);
    chk("R5 held in read", rd_data, byte_of(1'b0, 1'b1));
    rd_stb = 1'b0;
    step(1);
    chk("R5 cleared", rd_data, byte_of(1'b0, 1'b0));
  endtask

  task automatic t_loop_switch;
    mcr_rts = 1'b1;
    loop_en = 1'b1;
    step(1);
    chk("R9 switch sets delta", rd_data, byte_of(1'b1, 1'b1));
    host_read(2);
    chk("R5 clear again", rd_data, byte_of(1'b1, 1'b0));
  endtask

  task automatic t_loop_ignore;
    cts_n = 1'b0;
    step(SYNC + 3);
    chk("R3 pin ignored", rd_data, byte_of(1'b1, 1'b0));
    mcr_rts = 1'b0;
    step(1);
    chk("R3 follows rts", rd_data, byte_of(1'b0, 1'b1));
    host_read(1);
    chk("R5 clear after rts", rd_data, byte_of(1'b0, 1'b0));
  endtask

  task automatic t_change_in_read_flag_clear;
    rd_stb = 1'b1;
    step(1);
    mcr_rts = 1'b1;
    step(2);
    chk("R6 no set in read", rd_data, byte_of(1'b1, 1'b0));
    rd_stb = 1'b0;
    step(1);
    chk("R6 set at trailing", rd_data, byte_of(1'b1, 1'b1));
  endtask

  task automatic t_change_in_read_flag_set;
    rd_stb = 1'b1;
    step(1);
    mcr_rts = 1'b0;
    step(2);
    chk("R7 held in read", rd_data, byte_of(1'b0, 1'b1));
    rd_stb = 1'b0;
    step(1);
    chk("R7 cleared at trailing", rd_data, byte_of(1'b0, 1'b0));
    step(2);
    chk("R7 stays clear", rd_data, byte_of(1'b0, 1'b0));
  endtask

  task automatic t_back_to_pin;
    loop_en = 1'b0;
    step(1);
    chk("R9 back to pin", rd_data, byte_of(1'b1, 1'b1));
    host_read(2);
    cts_n = 1'b1;
    step(SYNC + 1);
    chk("R2 pin high again", rd_data, byte_of(1'b0, 1'b1));
    chk("R8 unused final", rd_data & 8'hEE, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_ext_level();
    t_read_clear();
    t_loop_switch();
    t_loop_ignore();
    t_change_in_read_flag_clear();
    t_change_in_read_flag_set();
    t_back_to_pin();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule